// File: doc/BRIEF.md
# Compare Match Timer Channel

One timer channel sits on a small synchronous register bus. A free prescaler divides the system clock by one of four ratios, and a 16-bit up-counter advances on each prescaled tick while the start input is high. When a tick arrives and the counter equals the compare register, the counter wraps to zero and a sticky match flag is set. If the interrupt enable is set, the interrupt output follows the flag.

Software clears the flag with a two-step handshake. It first reads the control/status register while the flag shows 1, and then writes 0 to the flag bit. Any hardware set of the flag cancels a pending read qualification. A match that lands between the read and the write therefore survives, and a stale read cannot clear a later match.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x0000, the counter (address 1) reads 0x0000, the compare register (address 2) reads 0xFFFF and irq_o is low.
- R2: In the control/status register, bits 15..8 and 5..2 always read 0, and writes to them are ignored.
- R3: Clock-select bits 1..0 with codes 0, 1, 2 and 3 pick divide ratios of 8, 32, 128 and 512. The counter advances only while start_i is high. The prescaler restarts whenever start_i is low, so the first tick comes on the ratio-th rising edge after start_i rises.
- R4: On the tick where the counter equals the compare value, the counter goes to 0 and the flag (bit 7) is set on the same edge. The first match after starting from 0 therefore comes (compare+1)*ratio edges after start.
- R5: Writing 1 to the flag bit has no effect on the flag.
- R6: A write of 0 to the flag bit clears it only if an earlier bus read of the control/status register (re_i high) saw the flag as 1. Without such a read the write has no effect.
- R7: A hardware set in the same cycle as a qualified clear wins. Any hardware set cancels a pending read qualification, so a later write of 0 does not clear the flag until a new read.
- R8: irq_o is high exactly when the flag and the interrupt enable (bit 6) are both 1.
- R9: The counter and compare registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Count enable |
| addr_i | input | 2 | Register select: 0 control/status, 1 counter, 2 compare |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (qualifies a flag clear) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Compare match interrupt |

## Verification
The bench uses the default parameters: a 16-bit data path and a base divide shift of 3 stepping by 2. It keeps the compare values small (below 16), so every divide ratio, including 512, reaches several wraps within a short run. Exact match edges can then be checked for all four clock-select codes. The same small periods let the bench place a clear write on the very edge of a second match.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned N_SEL    = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR = 2'd0,
    REG_CNT = 2'd1,
    REG_CMP = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler #(
  parameter int unsigned BASE_LOG = 3,
  parameter int unsigned STEP_LOG = 2,
  localparam int unsigned PW = BASE_LOG + STEP_LOG * (cmt_pkg::N_SEL - 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic [cmt_pkg::SEL_W-1:0] sel_i,
  output logic                     tick_o
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask_a [cmt_pkg::N_SEL];

  for (genvar g = 0; g < cmt_pkg::N_SEL; g++) begin : g_mask
    assign mask_a[g] = PW'((64'd1 << (BASE_LOG + STEP_LOG * g)) - 64'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (!run_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && ((pre_q & mask_a[sel_i]) == mask_a[sel_i]);

  // prescaler restarts while stopped, so no tick right after
  assert_idle_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tick_o);
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_cnt_i,
  input  logic          wr_cmp_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cmp_o,
  output logic          match_o
);
  logic [DW-1:0] cnt_q, cmp_q;

  assign match_o = tick_i && (cnt_q == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_cnt_i) cnt_q <= wdata_i;
    else if (match_o)  cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '1;
    else if (wr_cmp_i) cmp_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (cnt_q == cmp_q) && !wr_cnt_i) |=> (cnt_q == '0));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cmt_flag.sv
`timescale 1ns/1ps
module cmt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_wr_i,
  output logic flag_o
);
  logic flag_q, armed_q, clr;

  assign clr = clr_wr_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  // any set or clear drops the read qualification
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b0;
    else if (set_i || clr)      armed_q <= 1'b0;
    else if (rd_i && flag_q)    armed_q <= 1'b1;
  end

  assign flag_o = flag_q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);

  assert_clear_needs_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(armed_q));

  assert_armed_implies_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> flag_q);
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel #(
  parameter int unsigned DW       = 16,
  parameter int unsigned BASE_LOG = 3,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [cmt_pkg::ADDR_W-1:0] addr_i,
  input  logic                      we_i,
  input  logic                      re_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  output logic                      irq_o
);
  import cmt_pkg::*;

  logic                 sel_csr, sel_cnt, sel_cmp;
  logic                 ie_q;
  logic [SEL_W-1:0]     cks_q;
  logic                 tick, match, flag;
  logic [DW-1:0]        cnt, cmp, csr;

  assign sel_csr = (addr_i == REG_CSR);
  assign sel_cnt = (addr_i == REG_CNT);
  assign sel_cmp = (addr_i == REG_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      cks_q <= '0;
    end else if (we_i && sel_csr) begin
      ie_q  <= wdata_i[IE_BIT];
      cks_q <= wdata_i[SEL_W-1:0];
    end
  end

  cmt_prescaler #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_pre (
    .clk_i, .rst_ni, .run_i(start_i), .sel_i(cks_q), .tick_o(tick)
  );

  cmt_counter #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick),
    .wr_cnt_i(we_i && sel_cnt), .wr_cmp_i(we_i && sel_cmp),
    .wdata_i, .cnt_o(cnt), .cmp_o(cmp), .match_o(match)
  );

  cmt_flag u_flag (
    .clk_i, .rst_ni, .set_i(match),
    .rd_i(re_i && sel_csr),
    .clr_wr_i(we_i && sel_csr && !wdata_i[FLAG_BIT]),
    .flag_o(flag)
  );

  always_comb begin
    csr              = '0;
    csr[FLAG_BIT]    = flag;
    csr[IE_BIT]      = ie_q;
    csr[SEL_W-1:0]   = cks_q;
  end

  always_comb begin
    unique case (addr_i)
      REG_CSR: rdata_o = csr;
      REG_CNT: rdata_o = cnt;
      REG_CMP: rdata_o = cmp;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag && ie_q;

  assert_irq_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_csr && !wdata_i[IE_BIT] && !match) |=> !irq_o);
endmodule

// File: tb/sim_cmt_channel.sv
`timescale 1ns/1ps
module sim_cmt_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0, re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  cmt_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .we_i(we), .re_i(re), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int exp_ratio(input int cks);
    return 1 << (3 + 2 * cks);
  endfunction

  function automatic int exp_period(input int cmpv, input int cks);
    return (cmpv + 1) * exp_ratio(cks);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_csr();
    @(negedge clk);
    addr = 2'd0; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic clear_flag();
    rd_csr();
    wr(2'd0, 16'h0000);
  endtask

  // run one period from counter 0 and check the exact match edge
  task automatic run_period(input int cmpv, input int cks, input logic ie, input logic keep);
    logic [15:0] v;
    int n;
    start = 1'b0;
    clear_flag();
    wr(2'd2, 16'(cmpv));
    wr(2'd0, 16'((int'(ie) << 6) | cks));
    wr(2'd1, 16'h0000);
    @(negedge clk);
    start = 1'b1;
    n = exp_period(cmpv, cks);
    repeat (n - 1) @(posedge clk);
    #1 peek(2'd0, v);
    chk(v[7] == 1'b0, "R3 flag low one edge before match", int'(v[7]), 0);
    chk(irq == 1'b0, "R8 irq low before match", int'(irq), 0);
    @(posedge clk);
    #1 peek(2'd0, v);
    chk(v[7] == 1'b1, "R4 flag set on match edge", int'(v[7]), 1);
    chk(irq == ie, "R8 irq equals enable with flag set", int'(irq), int'(ie));
    peek(2'd1, v);
    chk(v == 16'h0000, "R4 counter wrapped to zero", int'(v), 0);
    if (!keep) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    peek(2'd0, v); chk(v == 16'h0000, "R1 csr reset", int'(v), 0);
    peek(2'd1, v); chk(v == 16'h0000, "R1 cnt reset", int'(v), 0);
    peek(2'd2, v); chk(v == 16'hFFFF, "R1 cmp reset", int'(v), 'hFFFF);
    chk(irq == 1'b0, "R1 irq reset", int'(irq), 0);

    // R9 counter and compare read back
    wr(2'd1, 16'h1234); peek(2'd1, v); chk(v == 16'h1234, "R9 cnt readback", int'(v), 'h1234);
    wr(2'd2, 16'hBEEF); peek(2'd2, v); chk(v == 16'hBEEF, "R9 cmp readback", int'(v), 'hBEEF);

    // R3 no advance while stopped
    repeat (100) @(negedge clk);
    peek(2'd1, v); chk(v == 16'h1234, "R3 counter held while stopped", int'(v), 'h1234);

    // R2 reserved bits, R5 write of 1 to clear flag
    wr(2'd0, 16'hFFFF); peek(2'd0, v); chk(v == 16'h0043, "R2 reserved bits read 0", int'(v), 'h43);
    wr(2'd0, 16'h0000); peek(2'd0, v); chk(v == 16'h0000, "R2 csr written back to 0", int'(v), 0);

    // R4 directed periods for every ratio
    for (int c = 0; c < 4; c++) run_period(2, c, 1'b1, 1'b0);
    run_period(0, 0, 1'b0, 1'b0);

    // R6 write 0 without read: no effect
    wr(2'd0, 16'h0000); peek(2'd0, v);
    chk(v[7] == 1'b1, "R6 clear without read ignored", int'(v[7]), 1);
    // R5 write 1 after read: no effect, then qualified write 0 clears
    rd_csr();
    wr(2'd0, 16'h0080); peek(2'd0, v);
    chk(v[7] == 1'b1, "R5 write 1 leaves flag", int'(v[7]), 1);
    wr(2'd0, 16'h0000); peek(2'd0, v);
    chk(v[7] == 1'b0, "R6 qualified clear", int'(v[7]), 0);

    // R7 clear write on the same edge as a new match
    run_period(3, 0, 1'b1, 1'b1);
    @(negedge clk); addr = 2'd0; re = 1'b1;
    @(negedge clk); re = 1'b0;
    repeat (30) @(negedge clk);
    addr = 2'd0; wdata = 16'h0040; we = 1'b1;
    @(negedge clk); we = 1'b0;
    start = 1'b0;
    peek(2'd0, v);
    chk(v[7] == 1'b1, "R7 set wins over clear", int'(v[7]), 1);
    chk(irq == 1'b1, "R8 irq held after race", int'(irq), 1);
    wr(2'd0, 16'h0040); peek(2'd0, v);
    chk(v[7] == 1'b1, "R7 qualification cancelled by set", int'(v[7]), 1);
    rd_csr(); wr(2'd0, 16'h0000); peek(2'd0, v);
    chk(v[7] == 1'b0, "R7 fresh read then clear", int'(v[7]), 0);
    chk(irq == 1'b0, "R8 irq low after clear", int'(irq), 0);

    // random periods
    for (int i = 0; i < 10; i++) begin
      int cm, ck;
      logic ie;
      cm = int'($urandom % 12);
      ck = int'($urandom % 4);
      ie = 1'($urandom % 2);
      run_period(cm, ck, ie, 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule